// File: doc/BRIEF.md
# Pixel Hit Timestamp Cell

This block is the digital recorder inside one pixel of a time-resolved gas-detector readout array. It runs on the 40 MHz crossing clock. When the pixel's discriminator fires, the block captures three things: the bunch-crossing number broadcast to the whole array, a 4-bit fine-phase code that places the hit inside the 25 ns crossing period, and the number of clock periods the discriminator stays above threshold (time over threshold). Together these give the arrival time and the pulse height of a single drift electron.

The cell keeps exactly one event. Once a measurement is complete, the cell ignores further discriminator activity until the readout logic clears it. Acquisition does not depend on readout. A single enable line shared by every pixel decides whether new hits may start; there is no shutter. The readout logic uses a select strobe to see the stored word, and it can ask for a shortened 6-bit time-over-threshold field taken from either the top or the bottom of the 8-bit count.

Top module: `pixel_hit_cell`

## Requirements
- R1: While `rst` is high at a clock edge, no event is stored and no measurement is in progress. At the edge after reset is released, `hit_valid` is 0 and `hit_word` is all zeros.
- R2: `disc_in` passes through two synchronizing flops before edge detection. For a rising edge of `disc_in` first seen at clock edge n, the stored crossing stamp is the `bx_count` value present at edge n+2.
- R3: The fine code is sampled at the same edge as the crossing stamp. Codes 0 to 14 are stored unchanged, and code 15 is stored as 14.
- R4: If `disc_in` is high for K consecutive clock edges (K ≥ 1), the stored time over threshold is K. The event becomes valid only after the synchronized discriminator has fallen.
- R5: The time-over-threshold count saturates at 255 and does not wrap.
- R6: A rising edge that arrives while `pix_en` is low starts no measurement, so no event is stored.
- R7: While an event is stored, or while a measurement is in progress, new rising edges are ignored, and the stored word does not change until it is cleared.
- R8: A high `rd_clr` at a clock edge discards the stored event and any measurement in progress. It takes priority over a rising edge detected in the same cycle. After a clear, the next enabled pulse is captured normally.
- R9: The outputs are registered. At the edge after one where `rd_sel` is high and an event is stored, `hit_valid` is 1 and `hit_word` is {stamp[22:12], fine[11:8], tot field[7:0]}. Otherwise both outputs are zero.
- R10: With `tot_short` high, the tot field is two zero bits followed by count[7:2] when `tot_msb_sel` is 1, or by count[5:0] when `tot_msb_sel` is 0. With `tot_short` low, the field is the full count. The field is formed at readout, so changing the mode reformats an event that is already stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Array-wide acquisition enable |
| disc_in | input | 1 | Asynchronous discriminator output |
| fine_code | input | 4 | Fine-phase code from the oscillator, 0 to 14 legal |
| bx_count | input | 11 | Broadcast bunch-crossing counter |
| tot_short | input | 1 | Select the 6-bit time-over-threshold field |
| tot_msb_sel | input | 1 | In short mode, 1 takes the top six bits and 0 the bottom six |
| rd_sel | input | 1 | Readout select for this pixel |
| rd_clr | input | 1 | Discard the stored event |
| hit_word | output | 23 | Packed stamp, fine code and time over threshold |
| hit_valid | output | 1 | `hit_word` carries a stored event |

## Verification
The assertions check, on every cycle: outputs are zero unless a select was seen with an event stored, the stored word stays frozen while it is held, a clear empties the cell on the next edge, no measurement runs while an event is held, the count stays pinned once saturated, and fine code 15 never reaches the output. Only the bench scenarios can show the values captured. These are the exact crossing stamp implied by the two-flop synchronizer latency, the pulse-length count, the clamping of the fine code, the effect of the enable and of lockout on later pulses, the priority of a clear over a same-cycle edge, and the two truncation modes applied to one stored count.

// File: rtl/pixhit_pkg.sv
`timescale 1ns/1ps
package pixhit_pkg;
  parameter int BX_W_DEF      = 11;
  parameter int FINE_W_DEF    = 4;
  parameter int FINE_MAX_DEF  = 14;
  parameter int TOT_W_DEF     = 8;
  parameter int TOT_SHORT_DEF = 6;
  parameter int SYNC_DEF      = 2;
endpackage

// File: rtl/pixhit_sync_edge.sv
`timescale 1ns/1ps
module pixhit_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // one flop per synchronizer stage
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pixhit_tot_cnt.sv
`timescale 1ns/1ps
module pixhit_tot_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         level,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      count <= CNT_ONE;
    end else if (busy) begin
      if (level) begin
        if (count != CNT_MAX) count <= count + CNT_ONE;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign done = busy & ~level & ~clr;
endmodule

// File: rtl/pixhit_store.sv
`timescale 1ns/1ps
module pixhit_store #(
  parameter int BX_W     = 11,
  parameter int FINE_W   = 4,
  parameter int FINE_MAX = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              start,
  input  logic              done,
  input  logic [BX_W-1:0]   bx_in,
  input  logic [FINE_W-1:0] fine_in,
  output logic              valid,
  output logic [BX_W-1:0]   bx_q,
  output logic [FINE_W-1:0] fine_q
);
  localparam logic [FINE_W-1:0] FINE_CAP = FINE_W'(FINE_MAX);

  logic [FINE_W-1:0] fine_lim;
  assign fine_lim = (fine_in > FINE_CAP) ? FINE_CAP : fine_in;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid  <= 1'b0;
      bx_q   <= '0;
      fine_q <= '0;
    end else begin
      if (start) begin
        bx_q   <= bx_in;
        fine_q <= fine_lim;
      end
      if (done) valid <= 1'b1;
    end
  end
endmodule

// File: rtl/pixel_hit_cell.sv
`timescale 1ns/1ps
module pixel_hit_cell
  import pixhit_pkg::*;
#(
  parameter int BX_W      = BX_W_DEF,
  parameter int FINE_W    = FINE_W_DEF,
  parameter int FINE_MAX  = FINE_MAX_DEF,
  parameter int TOT_W     = TOT_W_DEF,
  parameter int TOT_SHORT = TOT_SHORT_DEF,
  parameter int SYNC      = SYNC_DEF,
  parameter int WORD_W    = BX_W + FINE_W + TOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              disc_in,
  input  logic [FINE_W-1:0] fine_code,
  input  logic [BX_W-1:0]   bx_count,
  input  logic              tot_short,
  input  logic              tot_msb_sel,
  input  logic              rd_sel,
  input  logic              rd_clr,
  output logic [WORD_W-1:0] hit_word,
  output logic              hit_valid
);
  localparam int PAD = TOT_W - TOT_SHORT;

  logic              disc_lvl, disc_rise;
  logic              busy, done, held_valid, start;
  logic [TOT_W-1:0]  tot_cnt;
  logic [BX_W-1:0]   bx_q;
  logic [FINE_W-1:0] fine_q;
  logic [TOT_W-1:0]  tot_field;
  logic [WORD_W-1:0] stored;

  pixhit_sync_edge #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .din(disc_in), .level(disc_lvl), .rise(disc_rise)
  );

  assign start = disc_rise & pix_en & ~held_valid & ~busy & ~rd_clr;

  pixhit_tot_cnt #(.W(TOT_W)) u_tot (
    .clk(clk), .rst(rst), .clr(rd_clr), .start(start), .level(disc_lvl),
    .busy(busy), .done(done), .count(tot_cnt)
  );

  pixhit_store #(.BX_W(BX_W), .FINE_W(FINE_W), .FINE_MAX(FINE_MAX)) u_store (
    .clk(clk), .rst(rst), .clr(rd_clr), .start(start), .done(done),
    .bx_in(bx_count), .fine_in(fine_code),
    .valid(held_valid), .bx_q(bx_q), .fine_q(fine_q)
  );

  always_comb begin
    if (!tot_short)       tot_field = tot_cnt;
    else if (tot_msb_sel) tot_field = {{PAD{1'b0}}, tot_cnt[TOT_W-1 -: TOT_SHORT]};
    else                  tot_field = {{PAD{1'b0}}, tot_cnt[TOT_SHORT-1:0]};
  end

  assign stored = {bx_q, fine_q, tot_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit_word  <= '0;
    end else begin
      hit_valid <= rd_sel & held_valid;
      hit_word  <= (rd_sel & held_valid) ? {bx_q, fine_q, tot_field} : '0;
    end
  end
endmodule

// File: rtl/pixhit_chk.sv
`timescale 1ns/1ps
module pixhit_chk #(
  parameter int FINE_W   = 4,
  parameter int FINE_MAX = 14,
  parameter int TOT_W    = 8,
  parameter int WORD_W   = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_sel,
  input logic              rd_clr,
  input logic              hit_valid,
  input logic [WORD_W-1:0] hit_word,
  input logic              held_valid,
  input logic              busy,
  input logic [TOT_W-1:0]  tot_cnt,
  input logic [WORD_W-1:0] stored
);
  // R9
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> ($past(rd_sel) && $past(held_valid)));
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_valid |-> (hit_word == '0));
  // R3
  fine_legal_chk: assert property (@(posedge clk) disable iff (rst)
    hit_word[TOT_W +: FINE_W] <= FINE_W'(FINE_MAX));
  // R7
  held_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (held_valid && $past(held_valid)) |-> $stable(stored));
  // R7
  no_run_when_held_chk: assert property (@(posedge clk) disable iff (rst)
    held_valid |-> !busy);
  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> (!held_valid && !busy));
  // R5
  tot_pinned_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && ($past(tot_cnt) == {TOT_W{1'b1}})) |-> (tot_cnt == {TOT_W{1'b1}}));
endmodule

bind pixel_hit_cell pixhit_chk #(
  .FINE_W(FINE_W), .FINE_MAX(FINE_MAX), .TOT_W(TOT_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_clr(rd_clr),
  .hit_valid(hit_valid), .hit_word(hit_word), .held_valid(held_valid),
  .busy(busy), .tot_cnt(tot_cnt), .stored(stored)
);

// File: tb/sim_pixel_hit_cell.sv
`timescale 1ns/1ps
module sim_pixel_hit_cell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0;
  logic        disc_in = 1'b0;
  logic [3:0]  fine_code = 4'd0;
  logic [10:0] bx_count = 11'd0;
  logic        tot_short = 1'b0;
  logic        tot_msb_sel = 1'b0;
  logic        rd_sel = 1'b0;
  logic        rd_clr = 1'b0;
  logic [22:0] hit_word;
  logic        hit_valid;

  int total = 0;
  int fails = 0;
  int edge_cnt = 0;
  int last_e0 = 0;

  always #5 clk = ~clk;

  pixel_hit_cell u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .disc_in(disc_in),
    .fine_code(fine_code), .bx_count(bx_count), .tot_short(tot_short),
    .tot_msb_sel(tot_msb_sel), .rd_sel(rd_sel), .rd_clr(rd_clr),
    .hit_word(hit_word), .hit_valid(hit_valid)
  );

  always @(posedge clk) edge_cnt <= edge_cnt + 1;
  always @(negedge clk) bx_count <= edge_cnt[10:0];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int k, input logic [3:0] f);
    @(negedge clk);
    disc_in   = 1'b1;
    fine_code = f;
    last_e0   = edge_cnt;
    repeat (k) @(negedge clk);
    disc_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_out(output logic v, output logic [22:0] w);
    @(negedge clk);
    rd_sel = 1'b1;
    @(negedge clk);
    v = hit_valid;
    w = hit_word;
    rd_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_cell();
    @(negedge clk);
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(hit_valid == 1'b0, "R1 valid after reset", int'(hit_valid), 0);
    chk(hit_word == '0, "R1 word after reset", int'(hit_word), 0);
  endtask

  task automatic t_basic();
    logic v; logic [22:0] w;
    pix_en = 1'b1;
    pulse(5, 4'd9);
    read_out(v, w);
    chk(v == 1'b1, "R9 valid on select", int'(v), 1);
    chk(int'(w[22:12]) == ((last_e0 + 2) & 11'h7FF), "R2 stamp", int'(w[22:12]), (last_e0 + 2) & 11'h7FF);
    chk(w[11:8] == 4'd9, "R3 fine kept", int'(w[11:8]), 9);
    chk(w[7:0] == 8'd5, "R4 tot length", int'(w[7:0]), 5);
    @(negedge clk);
    chk(hit_valid == 1'b0 && hit_word == '0, "R9 idle zero", int'(hit_word), 0);
    clear_cell();
  endtask

  task automatic t_fine_and_short();
    logic v; logic [22:0] w;
    pulse(1, 4'd15);
    read_out(v, w);
    chk(w[11:8] == 4'd14, "R3 code 15 clamped", int'(w[11:8]), 14);
    chk(w[7:0] == 8'd1, "R4 single cycle", int'(w[7:0]), 1);
    clear_cell();
  endtask

  task automatic t_saturate();
    logic v; logic [22:0] w;
    pulse(300, 4'd0);
    read_out(v, w);
    chk(v && w[7:0] == 8'd255, "R5 saturation", int'(w[7:0]), 255);
    clear_cell();
  endtask

  task automatic t_enable();
    logic v; logic [22:0] w;
    pix_en = 1'b0;
    pulse(4, 4'd3);
    read_out(v, w);
    chk(v == 1'b0, "R6 disabled pulse ignored", int'(v), 0);
    pix_en = 1'b1;
  endtask

  task automatic t_lockout();
    logic v; logic [22:0] w;
    int e_first;
    pulse(7, 4'd2);
    e_first = last_e0;
    pulse(3, 4'd11);
    read_out(v, w);
    chk(int'(w[22:12]) == ((e_first + 2) & 11'h7FF), "R7 stamp kept", int'(w[22:12]), (e_first + 2) & 11'h7FF);
    chk(w[11:8] == 4'd2 && w[7:0] == 8'd7, "R7 fine and tot kept", int'(w[11:0]), (2 << 8) | 7);
    clear_cell();
    read_out(v, w);
    chk(v == 1'b0, "R8 cleared", int'(v), 0);
    pulse(3, 4'd11);
    read_out(v, w);
    chk(v && w[11:8] == 4'd11 && w[7:0] == 8'd3, "R8 capture after clear", int'(w[11:0]), (11 << 8) | 3);
    clear_cell();
  endtask

  task automatic t_clear_priority();
    logic v; logic [22:0] w;
    @(negedge clk);
    disc_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    repeat (3) @(negedge clk);
    disc_in = 1'b0;
    repeat (6) @(negedge clk);
    read_out(v, w);
    chk(v == 1'b0, "R8 clear beats edge", int'(v), 0);
  endtask

  task automatic t_trunc();
    logic v; logic [22:0] w;
    pulse(183, 4'd4);
    read_out(v, w);
    chk(w[7:0] == 8'd183, "R10 full field", int'(w[7:0]), 183);
    tot_short = 1'b1; tot_msb_sel = 1'b1;
    read_out(v, w);
    chk(w[7:0] == 8'd45, "R10 top six bits", int'(w[7:0]), 45);
    tot_msb_sel = 1'b0;
    read_out(v, w);
    chk(w[7:0] == 8'd55, "R10 bottom six bits", int'(w[7:0]), 55);
    tot_short = 1'b0;
    clear_cell();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fine_and_short();
    t_saturate();
    t_enable();
    t_lockout();
    t_clear_priority();
    t_trunc();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule